// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block holds the four power-mode bits of a processor status word and turns them into enables for the clock tree and oscillators: the core clock, the fast peripheral clock, the slow auxiliary clock, the digitally controlled oscillator (DCO), the DCO's DC bias generator and the crystal oscillator. Software writes the mode bits to enter a sleep mode. The interrupt-accept strobe saves the current bits and clears the ones that keep the core asleep. The return strobe loads a restored copy, which may have been edited so that the core resumes awake.

All enables are registered. They follow the mode register one clock edge after it changes, so no combinational path runs from a mode write to a clock gate. A wake filter masks the incoming wake lines according to which clocks are still running in the current mode, and it drives a single wake request.

Mode word encoding used on every mode port: bit 3 = SCG1 (fast clock gate), bit 2 = SCG0 (DC generator gate), bit 1 = OSCOFF (crystal off), bit 0 = CPUOFF (core off).

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o and stack_o are 0000 and all six clock/oscillator enables and cpu_running_o are 1.
- R2: With sr_we_i high at a clock edge, mode_o takes sr_wdata_i at that edge. The enables reflect the new mode at the following edge, not before.
- R3: Mode 0000 (active) enables everything. Mode 0001 turns off only the core clock. cpu_running_o always equals cpu_clk_en_o.
- R4: In mode 0101 the core clock is off and the fast and auxiliary clocks and the crystal stay on. The DCO and its DC generator are on when dco_used_i is 1 and off when it is 0.
- R5: Mode 1001 enables only the auxiliary clock, the DC generator and the crystal. Mode 1101 enables only the auxiliary clock and the crystal.
- R6: Whenever bits 1 and 0 are both 1, all six enables are 0, whatever bits 3 and 2 hold.
- R7: On irq_accept_i, stack_o takes the current mode word. Bits 3, 1 and 0 of mode_o are cleared, bit 2 is kept, and the core clock turns on one edge later.
- R8: On reti_i, mode_o takes reti_sr_i. An unedited copy re-enters the saved sleep mode, and a copy of 0000 resumes active mode.
- R9: If strobes coincide, irq_accept_i wins over reti_i, which wins over sr_we_i.
- R10: wake_o is the OR of the allowed wake classes. In the modes of R6 only ext_wake_i counts. In modes with bits 3 and 0 set (and not R6), ext_wake_i and aux_wake_i count. In all other modes, all three classes count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sr_we_i | input | 1 | Software write of mode bits |
| sr_wdata_i | input | 4 | Mode bits to write |
| irq_accept_i | input | 1 | Interrupt accepted strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reti_sr_i | input | 4 | Restored mode bits from the stacked copy |
| dco_used_i | input | 1 | DCO sources core or fast clock in active mode |
| ext_wake_i | input | N_EXT | Wake lines from external pins / reset-NMI |
| aux_wake_i | input | N_AUX | Wake lines from auxiliary-clocked peripherals |
| fast_wake_i | input | N_FAST | Wake lines from fast-clocked peripherals |
| mode_o | output | 4 | Current mode bits |
| stack_o | output | 4 | Mode bits saved at the last interrupt entry |
| cpu_clk_en_o | output | 1 | Core clock enable |
| fast_clk_en_o | output | 1 | Fast peripheral clock enable |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| dco_en_o | output | 1 | DCO enable |
| dcgen_en_o | output | 1 | DCO DC generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| cpu_running_o | output | 1 | Core is clocked |
| wake_o | output | 1 | Filtered wake request |

## Verification
A corrupted mode register shows on mode_o at once, and on the enables exactly one edge later. Any disagreement between the two therefore exposes either the register or the decode within two cycles of a write or strobe. A wrong saved copy stays hidden until a return strobe carries it back, so the bench compares stack_o directly right after each interrupt entry. Wake filter faults appear combinationally on wake_o and are probed one class at a time in every mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned LPM_W    = 4;
  localparam int unsigned CLK_EN_W = 6;

  typedef struct packed {
    logic scg1;
    logic scg0;
    logic osc_off;
    logic cpu_off;
  } lpm_bits_t;

  typedef struct packed {
    logic cpu;
    logic fast;
    logic aux;
    logic dco;
    logic dcgen;
    logic xtal;
  } clk_en_t;
endpackage

// File: rtl/lpm_sr_reg.sv
module lpm_sr_reg
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sr_we_i,
  input  lpm_bits_t sr_wdata_i,
  input  logic      irq_accept_i,
  input  logic      reti_i,
  input  lpm_bits_t reti_sr_i,
  output lpm_bits_t mode_o,
  output lpm_bits_t stack_o
);
  lpm_bits_t mode_q, stack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      stack_q <= '0;
    end else if (irq_accept_i) begin
      stack_q         <= mode_q;
      mode_q.scg1     <= 1'b0;
      mode_q.osc_off  <= 1'b0;
      mode_q.cpu_off  <= 1'b0;
    end else if (reti_i) begin
      mode_q <= reti_sr_i;
    end else if (sr_we_i) begin
      mode_q <= sr_wdata_i;
    end
  end

  assign mode_o  = mode_q;
  assign stack_o = stack_q;
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
  import lpm_pkg::*;
(
  input  lpm_bits_t mode_i,
  input  logic      dco_used_i,
  output clk_en_t   en_o
);
  logic deep;     // crystal stopped with core off
  logic dc_drop;  // SCG0 drops the DC generator

  always_comb begin
    deep     = mode_i.osc_off & mode_i.cpu_off;
    dc_drop  = mode_i.scg0 & ~(dco_used_i & ~mode_i.scg1);
    en_o.cpu   = ~mode_i.cpu_off;
    en_o.fast  = ~mode_i.scg1 & ~deep;
    en_o.aux   = ~mode_i.osc_off;
    en_o.xtal  = ~mode_i.osc_off;
    en_o.dco   = ~mode_i.scg1 & ~deep & ~(mode_i.scg0 & ~dco_used_i);
    en_o.dcgen = ~deep & ~dc_drop;
  end
endmodule

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
  import lpm_pkg::*;
#(
  parameter int unsigned N_EXT  = 2,
  parameter int unsigned N_AUX  = 2,
  parameter int unsigned N_FAST = 2
) (
  input  lpm_bits_t         mode_i,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic [N_AUX-1:0]  aux_i,
  input  logic [N_FAST-1:0] fast_i,
  output logic              wake_o
);
  logic deep, slow_only;

  always_comb begin
    deep      = mode_i.osc_off & mode_i.cpu_off;
    slow_only = mode_i.scg1 & mode_i.cpu_off & ~deep;
    wake_o    = (|ext_i)
              | ((|aux_i)  & ~deep)
              | ((|fast_i) & ~deep & ~slow_only);
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_EXT  = 2,
  parameter int unsigned N_AUX  = 2,
  parameter int unsigned N_FAST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_we_i,
  input  logic [3:0]        sr_wdata_i,
  input  logic              irq_accept_i,
  input  logic              reti_i,
  input  logic [3:0]        reti_sr_i,
  input  logic              dco_used_i,
  input  logic [N_EXT-1:0]  ext_wake_i,
  input  logic [N_AUX-1:0]  aux_wake_i,
  input  logic [N_FAST-1:0] fast_wake_i,
  output logic [3:0]        mode_o,
  output logic [3:0]        stack_o,
  output logic              cpu_clk_en_o,
  output logic              fast_clk_en_o,
  output logic              aux_clk_en_o,
  output logic              dco_en_o,
  output logic              dcgen_en_o,
  output logic              xtal_en_o,
  output logic              cpu_running_o,
  output logic              wake_o
);
  lpm_bits_t mode, stack;
  clk_en_t   en_d, en_q;

  lpm_sr_reg u_sr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_we_i      (sr_we_i),
    .sr_wdata_i   (lpm_bits_t'(sr_wdata_i)),
    .irq_accept_i (irq_accept_i),
    .reti_i       (reti_i),
    .reti_sr_i    (lpm_bits_t'(reti_sr_i)),
    .mode_o       (mode),
    .stack_o      (stack)
  );

  lpm_clk_decode u_dec (
    .mode_i     (mode),
    .dco_used_i (dco_used_i),
    .en_o       (en_d)
  );

  lpm_wake_filter #(.N_EXT(N_EXT), .N_AUX(N_AUX), .N_FAST(N_FAST)) u_wake (
    .mode_i (mode),
    .ext_i  (ext_wake_i),
    .aux_i  (aux_wake_i),
    .fast_i (fast_wake_i),
    .wake_o (wake_o)
  );

  // enables trail the mode register by one edge: glitch-free gate inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '1;
    else         en_q <= en_d;
  end

  assign mode_o        = mode;
  assign stack_o       = stack;
  assign cpu_clk_en_o  = en_q.cpu;
  assign fast_clk_en_o = en_q.fast;
  assign aux_clk_en_o  = en_q.aux;
  assign dco_en_o      = en_q.dco;
  assign dcgen_en_o    = en_q.dcgen;
  assign xtal_en_o     = en_q.xtal;
  assign cpu_running_o = en_q.cpu;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int unsigned N_EXT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_accept_i,
  input logic             reti_i,
  input logic [3:0]       reti_sr_i,
  input logic [N_EXT-1:0] ext_wake_i,
  input logic [3:0]       mode_o,
  input logic [3:0]       stack_o,
  input logic             cpu_clk_en_o,
  input logic             fast_clk_en_o,
  input logic             aux_clk_en_o,
  input logic             dco_en_o,
  input logic             dcgen_en_o,
  input logic             xtal_en_o,
  input logic             wake_o
);
  a_r3_cpu_off_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[0] |=> !cpu_clk_en_o);

  a_r6_deep_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && mode_o[0]) |=> !(cpu_clk_en_o || fast_clk_en_o || aux_clk_en_o ||
                                   dco_en_o || dcgen_en_o || xtal_en_o));

  a_r7_entry_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_accept_i |=> (!mode_o[3] && !mode_o[1] && !mode_o[0] &&
                      mode_o[2] == $past(mode_o[2])));

  a_r7_entry_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_accept_i |=> stack_o == $past(mode_o));

  a_r8_return_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !irq_accept_i) |=> mode_o == $past(reti_sr_i));

  a_r10_deep_ext_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && mode_o[0] && ext_wake_i == '0) |-> !wake_o);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.N_EXT(N_EXT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_accept_i  (irq_accept_i),
  .reti_i        (reti_i),
  .reti_sr_i     (reti_sr_i),
  .ext_wake_i    (ext_wake_i),
  .mode_o        (mode_o),
  .stack_o       (stack_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .fast_clk_en_o (fast_clk_en_o),
  .aux_clk_en_o  (aux_clk_en_o),
  .dco_en_o      (dco_en_o),
  .dcgen_en_o    (dcgen_en_o),
  .xtal_en_o     (xtal_en_o),
  .wake_o        (wake_o)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
  localparam int unsigned N_EXT = 2, N_AUX = 2, N_FAST = 2;
  localparam int unsigned NVEC = 10;
  // {mode[3:0], dco_used, en{cpu,fast,aux,dco,dcgen,xtal}, wake_allow{fast,aux,ext}}
  localparam logic [13:0] VEC [NVEC] = '{
    {4'b0000, 1'b1, 6'b111111, 3'b111},
    {4'b0000, 1'b0, 6'b111111, 3'b111},
    {4'b0001, 1'b1, 6'b011111, 3'b111},
    {4'b0101, 1'b1, 6'b011111, 3'b111},
    {4'b0101, 1'b0, 6'b011001, 3'b111},
    {4'b1001, 1'b1, 6'b001011, 3'b011},
    {4'b1101, 1'b1, 6'b001001, 3'b011},
    {4'b0011, 1'b1, 6'b000000, 3'b001},
    {4'b1111, 1'b0, 6'b000000, 3'b001},
    {4'b0111, 1'b1, 6'b000000, 3'b001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_we = 1'b0, irq = 1'b0, reti = 1'b0, dco_used = 1'b1;
  logic [3:0] sr_wdata = '0, reti_sr = '0;
  logic [N_EXT-1:0]  ext_w = '0;
  logic [N_AUX-1:0]  aux_w = '0;
  logic [N_FAST-1:0] fast_w = '0;
  logic [3:0] mode, stack;
  logic cpu_en, fast_en, aux_en, dco_en, dcgen_en, xtal_en, running, wake;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl #(.N_EXT(N_EXT), .N_AUX(N_AUX), .N_FAST(N_FAST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sr_we_i(sr_we), .sr_wdata_i(sr_wdata),
    .irq_accept_i(irq), .reti_i(reti), .reti_sr_i(reti_sr), .dco_used_i(dco_used),
    .ext_wake_i(ext_w), .aux_wake_i(aux_w), .fast_wake_i(fast_w),
    .mode_o(mode), .stack_o(stack), .cpu_clk_en_o(cpu_en), .fast_clk_en_o(fast_en),
    .aux_clk_en_o(aux_en), .dco_en_o(dco_en), .dcgen_en_o(dcgen_en), .xtal_en_o(xtal_en),
    .cpu_running_o(running), .wake_o(wake)
  );

  wire [5:0] en_vec = {cpu_en, fast_en, aux_en, dco_en, dcgen_en, xtal_en};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); sr_we = 1'b1; sr_wdata = m;
    @(negedge clk); sr_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
  endtask

  task automatic pulse_reti(input logic [3:0] m);
    @(negedge clk); reti = 1'b1; reti_sr = m;
    @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #12;
    check("R1 mode", mode, 4'b0000);
    check("R1 stack", stack, 4'b0000);
    check("R1 enables", en_vec, 6'b111111);
    check("R1 running", running, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R3 R4 R5 R6 R10: table walk
    for (int i = 0; i < NVEC; i++) begin
      dco_used = VEC[i][9];
      write_mode(VEC[i][13:10]);
      check("R2 mode", mode, VEC[i][13:10]);
      check("R3 R4 R5 R6 enables", en_vec, VEC[i][8:3]);
      check("R3 running", running, VEC[i][8]);
      ext_w = 2'b01; #0.5;
      check("R10 ext", wake, VEC[i][0]);
      ext_w = '0; aux_w = 2'b10; #0.5;
      check("R10 aux", wake, VEC[i][1]);
      aux_w = '0; fast_w = 2'b10; #0.5;
      check("R10 fast", wake, VEC[i][2]);
      fast_w = '0; #0.5;
      check("R10 none", wake, 1'b0);
    end

    // R2: enables lag the mode write by one edge
    dco_used = 1'b1;
    write_mode(4'b0000);
    @(negedge clk); sr_we = 1'b1; sr_wdata = 4'b0001;
    @(negedge clk); sr_we = 1'b0;
    check("R2 mode now", mode, 4'b0001);
    check("R2 cpu still on", cpu_en, 1'b1);
    @(negedge clk);
    check("R2 cpu off next", cpu_en, 1'b0);

    // R7: entry from sleep with SCG0 set
    write_mode(4'b1101);
    pulse_irq();
    check("R7 cleared keep scg0", mode, 4'b0100);
    check("R7 saved", stack, 4'b1101);
    check("R7 running lags", running, 1'b0);
    @(negedge clk);
    check("R7 awake enables", en_vec, 6'b111111);

    // R8: unedited copy returns to sleep
    pulse_reti(stack);
    check("R8 restored", mode, 4'b1101);
    @(negedge clk);
    check("R8 sleep enables", en_vec, 6'b001001);

    // R8: edited copy resumes active
    pulse_irq();
    pulse_reti(4'b0000);
    check("R8 edited mode", mode, 4'b0000);
    @(negedge clk);
    check("R8 edited enables", en_vec, 6'b111111);

    // R7: entry from deepest sleep
    write_mode(4'b0011);
    pulse_irq();
    check("R7 deep cleared", mode, 4'b0000);
    check("R7 deep saved", stack, 4'b0011);
    @(negedge clk);
    check("R7 deep running", running, 1'b1);

    // R9: irq beats reti
    write_mode(4'b0001);
    @(negedge clk); irq = 1'b1; reti = 1'b1; reti_sr = 4'b1111;
    @(negedge clk); irq = 1'b0; reti = 1'b0;
    check("R9 irq wins mode", mode, 4'b0000);
    check("R9 irq wins stack", stack, 4'b0001);
    // R9: reti beats write
    @(negedge clk); reti = 1'b1; reti_sr = 4'b1001; sr_we = 1'b1; sr_wdata = 4'b0001;
    @(negedge clk); reti = 1'b0; sr_we = 1'b0;
    check("R9 reti wins", mode, 4'b1001);

    // R1: asynchronous reset mid-run
    write_mode(4'b1101);
    #1 rst_n = 1'b0; #1;
    check("R1 async mode", mode, 4'b0000);
    check("R1 async enables", en_vec, 6'b111111);
    check("R1 async stack", stack, 4'b0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule